// File: doc/BRIEF.md
# Mono-to-Grayscale Pixel Expander

This block converts a stream of packed monochrome pixels, one bit each, into a stream of packed 4-bit grayscale segments for an OLED column driver. A lit pixel becomes a segment of all ones and a dark pixel becomes a segment of all zeros. Each pixel's segment is repeated a configurable number of times. Consecutive segments are paired into output bytes, with the first segment of each pair in the low nibble.

A transfer begins with a one-cycle `start` pulse. At that pulse the block captures the pixel count and the replication factor. Source bytes then arrive on a valid/ready input and result bytes leave on a valid/ready output, and either side may stall at any time. The final output byte is marked, and a one-cycle `done` pulse closes the transfer.

Top module: `mono_gray_expander`

## Requirements
- R1: While reset is held and after it is released, `out_valid`, `in_ready` and `done` are 0 until a transfer is started.
- R2: A pixel bit of 1 produces segment value 4'hF and a pixel bit of 0 produces 4'h0.
- R3: Pixel n of a transfer is taken from bit (n mod 8) of input byte n/8, least significant bit first.
- R4: Each pixel yields exactly `cfg_reps` (1 to 7) consecutive identical segments, using the value captured at start.
- R5: Segment 2k of a transfer is placed in `out_data[3:0]` of output byte k, and segment 2k+1 is placed in `out_data[7:4]`.
- R6: A transfer of N pixels and factor F emits exactly ceil(N*F/2) output bytes. When N*F is odd, the last byte carries the final segment in bits [3:0] and zero in bits [7:4].
- R7: A transfer consumes exactly ceil(N/8) input bytes. The unused high bits of a partial final byte are discarded, and after the last byte `in_ready` stays 0.
- R8: `in_ready` is 0 in the cycle after an input byte is accepted and stays 0 until every pixel of that byte has been expanded.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values.
- R10: `out_last` is 1 on the final output byte of a transfer and 0 on every other byte.
- R11: `done` is 1 for exactly one cycle: the cycle after the byte with `out_last` is accepted.
- R12: A `start` pulse is ignored while a transfer is in progress, and also when `cfg_pixels` or `cfg_reps` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a transfer, captures the configuration |
| cfg_pixels | input | PIX_W | Pixels in the transfer |
| cfg_reps | input | REP_W | Segments written per pixel |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Packed monochrome pixels, LSB first |
| in_ready | output | 1 | Block accepts an input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Two packed grayscale segments |
| out_last | output | 1 | Final output byte of the transfer |
| out_ready | input | 1 | Sink accepts the output byte |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
A fault in the bit index or in the replication counter appears in the first output byte as a misplaced or wrongly repeated nibble, usually within two cycles of the first accepted input byte. A fault in the pixel countdown shows up at the end of the transfer instead. It appears as a wrong output byte count, an extra or missing input fetch, or a misplaced `out_last` or `done`. A fault in the half-byte pairing corrupts the upper nibble of every odd segment and is visible on the first emitted byte.

// File: rtl/mxp_pkg.sv
package mxp_pkg;
  localparam int SEG_W  = 4;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = $clog2(BYTE_W);
  typedef logic [SEG_W-1:0]  seg_t;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/mxp_unpack.sv
module mxp_unpack
  import mxp_pkg::*;
#(
  parameter int PIX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PIX_W-1:0] load_pixels,
  input  logic             in_valid,
  input  byte_t            in_data,
  input  logic             step_pix,
  output logic             in_ready,
  output logic             have_byte,
  output logic             pix_bit,
  output logic             last_pix
);
  byte_t            cur_q, cur_n;
  logic             have_q, have_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [PIX_W-1:0] left_q, left_n;
  logic             in_fire;

  assign in_ready  = !have_q && (left_q != '0);
  assign in_fire   = in_valid && in_ready;
  assign have_byte = have_q;
  assign pix_bit   = cur_q[idx_q];
  assign last_pix  = (left_q == PIX_W'(1));

  always_comb begin
    cur_n  = cur_q;
    have_n = have_q;
    idx_n  = idx_q;
    left_n = left_q;
    if (load) begin
      left_n = load_pixels;
    end
    if (in_fire) begin
      cur_n  = in_data;
      have_n = 1'b1;
      idx_n  = '0;
    end
    if (step_pix) begin
      left_n = left_q - PIX_W'(1);
      idx_n  = idx_q + IDX_W'(1);
      if (idx_q == IDX_W'(BYTE_W - 1) || last_pix) begin
        have_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      have_q <= 1'b0;
      idx_q  <= '0;
      left_q <= '0;
    end else begin
      if (in_fire) cur_q <= cur_n;
      if (in_fire || step_pix) begin
        have_q <= have_n;
        idx_q  <= idx_n;
      end
      if (load || step_pix) left_q <= left_n;
    end
  end
endmodule

// File: rtl/mxp_repl.sv
module mxp_repl #(
  parameter int REP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REP_W-1:0] load_reps,
  input  logic             step,
  output logic             pix_done
);
  logic [REP_W-1:0] reps_q, reps_n;
  logic [REP_W-1:0] cnt_q, cnt_n;

  assign pix_done = (cnt_q == reps_q - REP_W'(1));

  always_comb begin
    reps_n = reps_q;
    cnt_n  = cnt_q;
    if (load) begin
      reps_n = load_reps;
      cnt_n  = '0;
    end else if (step) begin
      cnt_n = pix_done ? '0 : cnt_q + REP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reps_q <= REP_W'(1);
      cnt_q  <= '0;
    end else begin
      if (load) reps_q <= reps_n;
      if (load || step) cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/mxp_pack.sv
module mxp_pack
  import mxp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  seg_go,
  input  seg_t  seg_val,
  input  logic  seg_last,
  input  logic  out_ready,
  output logic  accept,
  output logic  out_valid,
  output byte_t out_data,
  output logic  out_last
);
  seg_t  lo_q, lo_n;
  logic  lo_full_q, lo_full_n;
  byte_t ob_q, ob_n;
  logic  ov_q, ov_n;
  logic  ol_q, ol_n;
  logic  emit;

  assign accept    = !ov_q || out_ready;
  assign emit      = seg_go && (lo_full_q || seg_last);
  assign out_valid = ov_q;
  assign out_data  = ob_q;
  assign out_last  = ol_q;

  always_comb begin
    lo_n      = lo_q;
    lo_full_n = lo_full_q;
    ob_n      = ob_q;
    ov_n      = ov_q;
    ol_n      = ol_q;
    if (ov_q && out_ready) ov_n = 1'b0;
    if (seg_go && !emit) begin
      lo_n      = seg_val;
      lo_full_n = 1'b1;
    end
    if (emit) begin
      ob_n      = lo_full_q ? {seg_val, lo_q} : {SEG_W'(0), seg_val};
      lo_full_n = 1'b0;
      ov_n      = 1'b1;
      ol_n      = seg_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q      <= '0;
      lo_full_q <= 1'b0;
      ob_q      <= '0;
      ov_q      <= 1'b0;
      ol_q      <= 1'b0;
    end else begin
      if (seg_go) begin
        lo_q      <= lo_n;
        lo_full_q <= lo_full_n;
      end
      if (emit) begin
        ob_q <= ob_n;
        ol_q <= ol_n;
      end
      ov_q <= ov_n;
    end
  end
endmodule

// File: rtl/mono_gray_expander.sv
module mono_gray_expander
  import mxp_pkg::*;
#(
  parameter int PIX_W = 16,
  parameter int REP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PIX_W-1:0] cfg_pixels,
  input  logic [REP_W-1:0] cfg_reps,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last,
  input  logic             out_ready,
  output logic             done
);
  logic run_q, run_n;
  logic done_q, done_n;
  logic load, have_byte, pix_bit, last_pix, pix_done;
  logic accept, seg_go, step_pix, seg_last, out_fire;
  seg_t seg_val;

  assign load     = start && !run_q && (cfg_pixels != '0) && (cfg_reps != '0);
  assign seg_go   = have_byte && accept;
  assign step_pix = seg_go && pix_done;
  assign seg_last = last_pix && pix_done;
  assign seg_val  = {SEG_W{pix_bit}};
  assign out_fire = out_valid && out_ready;
  assign done     = done_q;

  always_comb begin
    run_n  = run_q;
    done_n = out_fire && out_last;
    if (load) run_n = 1'b1;
    else if (out_fire && out_last) run_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_n;
      done_q <= done_n;
    end
  end

  mxp_unpack #(.PIX_W(PIX_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .load(load), .load_pixels(cfg_pixels),
    .in_valid(in_valid), .in_data(in_data), .step_pix(step_pix),
    .in_ready(in_ready), .have_byte(have_byte), .pix_bit(pix_bit),
    .last_pix(last_pix)
  );

  mxp_repl #(.REP_W(REP_W)) u_repl (
    .clk(clk), .rst_n(rst_n), .load(load), .load_reps(cfg_reps),
    .step(seg_go), .pix_done(pix_done)
  );

  mxp_pack u_pack (
    .clk(clk), .rst_n(rst_n), .seg_go(seg_go), .seg_val(seg_val),
    .seg_last(seg_last), .out_ready(out_ready), .accept(accept),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );
endmodule

// File: rtl/mxp_chk.sv
module mxp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       out_ready,
  input logic       done
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  p_done_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> done);

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_ready_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_nibble_values_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_data[3:0] == 4'h0 || out_data[3:0] == 4'hF) &&
                   (out_data[7:4] == 4'h0 || out_data[7:4] == 4'hF)));
endmodule

bind mono_gray_expander mxp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
  .out_ready(out_ready), .done(done)
);

// File: tb/sim_mono_gray_expander.sv
module sim_mono_gray_expander;
  localparam int CLK_P = 10;
  localparam int PIX_W = 16;
  localparam int REP_W = 3;
  localparam int WATCHDOG = 150000;

  logic clk, rst_n, start, in_valid, in_ready, out_valid, out_last, out_ready, done;
  logic [PIX_W-1:0] cfg_pixels;
  logic [REP_W-1:0] cfg_reps;
  logic [7:0] in_data, out_data;

  int errors = 0;
  int checks = 0;
  logic [7:0] src [32];
  logic [7:0] exp_b [1024];

  mono_gray_expander #(.PIX_W(PIX_W), .REP_W(REP_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_pixels(cfg_pixels),
    .cfg_reps(cfg_reps), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .out_ready(out_ready), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int build_expected(input int n, input int reps);
    int nseg = n * reps;
    int nb = (nseg + 1) / 2;
    for (int b = 0; b < nb; b++) exp_b[b] = 8'h00;
    for (int s = 0; s < nseg; s++) begin
      int p = s / reps;
      logic bitv = src[p / 8][p % 8];
      logic [3:0] nib = bitv ? 4'hF : 4'h0;
      if (s % 2 == 0) exp_b[s / 2][3:0] = nib;
      else            exp_b[s / 2][7:4] = nib;
    end
    return nb;
  endfunction

  task automatic run_xfer(input int n, input int reps, input int rdy_pct,
                          input int vld_pct, input bit poke);
    int nexp = build_expected(n, reps);
    int nin = (n + 7) / 8;
    int k = 0;
    @(negedge clk);
    cfg_pixels = PIX_W'(n);
    cfg_reps = REP_W'(reps);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fork
      begin
        for (int i = 0; i < nin; i++) begin
          if (poke && i == 1) begin
            in_valid = 1'b0;
            cfg_pixels = PIX_W'(3);
            cfg_reps = REP_W'(1);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
          end
          while (($urandom % 100) >= vld_pct) begin
            in_valid = 1'b0;
            @(negedge clk);
          end
          in_valid = 1'b1;
          in_data = src[i];
          while (!in_ready) @(negedge clk);
          @(negedge clk);
          check(in_ready == 1'b0, "R8 ready low after accept", in_ready, 0);
        end
        in_valid = 1'b0;
      end
      begin
        bit pend = 1'b0;
        bit hold = 1'b0;
        logic [7:0] hd = '0;
        logic hl = 1'b0;
        forever begin
          @(negedge clk);
          if (pend) begin
            check(done == 1'b1, "R11 done after last", done, 1);
            break;
          end
          if (done) check(1'b0, "R11 early done", done, 0);
          if (hold)
            check(out_valid && out_data == hd && out_last == hl,
                  "R9 hold under stall", out_data, hd);
          out_ready = (($urandom % 100) < rdy_pct);
          hold = out_valid && !out_ready;
          hd = out_data;
          hl = out_last;
          if (out_valid && out_ready) begin
            check(k < nexp && out_data == exp_b[k], "R2 R3 R4 R5 data", out_data,
                  (k < nexp) ? exp_b[k] : 0);
            check(out_last == (k == nexp - 1), "R10 last flag", out_last, (k == nexp - 1));
            k++;
            if (out_last) pend = 1'b1;
          end
        end
        out_ready = 1'b0;
      end
    join
    check(k == nexp, "R6 output byte count", k, nexp);
    @(negedge clk);
    check(done == 1'b0, "R11 single pulse", done, 0);
    in_valid = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(in_ready == 1'b0 && out_valid == 1'b0, "R7 no extra fetch", in_ready, 0);
    end
    in_valid = 1'b0;
  endtask

  task automatic bad_start(input int n, input int reps);
    @(negedge clk);
    cfg_pixels = PIX_W'(n);
    cfg_reps = REP_W'(reps);
    start = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check(in_ready == 1'b0 && out_valid == 1'b0, "R12 start ignored", in_ready, 0);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; in_data = '0;
    out_ready = 1'b0; cfg_pixels = '0; cfg_reps = '0;
    repeat (3) @(negedge clk);
    check(!out_valid && !in_ready && !done, "R1 in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !in_ready && !done, "R1 after reset", in_ready, 0);

    src[0] = 8'h01;
    run_xfer(1, 1, 100, 100, 1'b0);
    src[0] = 8'hA5;
    run_xfer(8, 2, 100, 100, 1'b0);
    src[0] = 8'hFA;
    run_xfer(3, 3, 60, 70, 1'b0);
    src[0] = 8'h3C; src[1] = 8'hE1;
    run_xfer(13, 4, 50, 50, 1'b0);
    src[0] = 8'h96; src[1] = 8'h0F; src[2] = 8'h77;
    run_xfer(20, 7, 80, 90, 1'b1);
    bad_start(0, 2);
    bad_start(5, 0);
    for (int t = 0; t < 12; t++) begin
      int n = 1 + ($urandom % 200);
      int r = 1 + ($urandom % 7);
      for (int b = 0; b < 32; b++) src[b] = 8'($urandom);
      run_xfer(n, r, 30 + ($urandom % 71), 30 + ($urandom % 71), (t % 4) == 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule